// File: doc/BRIEF.md
# PCI Subtractive Decode Claimer

This block watches host cycles that reach the secondary PCI bus because no internal target matched their address. When subtractive claiming is on, it gives external PCI agents the first three decode clocks after the cycle starts. If none of them asserts DEVSEL in that time, the block drives DEVSEL itself in the fourth clock. It then drives STOP to end the PCI cycle and raises a one-cycle request to reissue the same cycle on the LPC bus.

When claiming is off, an unmatched cycle never touches PCI. The block raises the LPC request on the clock after the cycle start. The cycle type (memory or I/O) is captured at the start and presented alongside the LPC request.

The block tracks one cycle at a time. A start strobe that arrives while a cycle is in progress is ignored. Data phases on PCI and the LPC transfer itself belong to other logic.

Top module: `subtractive_claimer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `devsel_n_o` and `stop_n_o` are 1 and `lpc_route` and `pci_done` are 0.
- R2: With `sub_en` at 0 when `cyc_start` is sampled, `lpc_route` is 1 for exactly the one cycle after that edge, and `devsel_n_o` and `stop_n_o` stay at 1 throughout.
- R3: With `sub_en` at 1 and `ext_devsel_n` sampled at 1 on the three edges that follow the start, `devsel_n_o` goes to 0 in cycles 4 and 5 after the start. It is 1 in cycles 1 to 3. An external claim that first appears in cycle 4 does not stop the block from claiming.
- R4: On the claiming path, `stop_n_o` is 0 in cycle 5 only, and only while `devsel_n_o` is 0. Both outputs are 1 again from cycle 6.
- R5: On the claiming path, `lpc_route` is 1 in cycle 6 only, and `pci_done` stays 0.
- R6: With `sub_en` at 1, if `ext_devsel_n` is sampled at 0 on any of the first three edges after the start, the block never drives `devsel_n_o` or `stop_n_o` low and does not raise `lpc_route` for that cycle.
- R7: After such an external claim, `pci_done` is 1 for exactly the one cycle that follows the first edge on which `ext_devsel_n` is sampled at 1 again. If `ext_devsel_n` is last low in cycle m, that is cycle m+2.
- R8: A `cyc_start` sampled while a cycle is in progress has no effect on any output, and `lpc_is_io` keeps the value captured at the accepted start.
- R9: `sub_en` is sampled only together with an accepted `cyc_start`. Changing it while a cycle is in progress does not change that cycle's outputs.
- R10: `lpc_is_io` equals the `cyc_is_io` value sampled with the accepted start whenever `lpc_route` is 1 (1 = I/O, 0 = memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | Start of an unmatched host cycle, one-cycle strobe |
| cyc_is_io | input | 1 | Cycle type of the starting cycle, 1 = I/O, 0 = memory |
| sub_en | input | 1 | Subtractive claiming enable |
| ext_devsel_n | input | 1 | DEVSEL seen from external PCI agents, active low |
| devsel_n_o | output | 1 | DEVSEL drive from this block, active low |
| stop_n_o | output | 1 | STOP drive from this block, active low |
| lpc_route | output | 1 | One-cycle request to run the cycle on LPC |
| lpc_is_io | output | 1 | Captured cycle type that goes with `lpc_route` |
| pci_done | output | 1 | One-cycle pulse: cycle finished on PCI by an external agent |

## Verification
A wrong decode-slot count shows as `devsel_n_o` falling one clock early or late. It appears within four cycles of the start. A lost or wrong state transition shows up before the cycle ends: STOP without DEVSEL, a missing or doubled `lpc_route`, or a `pci_done` where an LPC reroute belongs. A start strobe that leaks through while the block is busy shows as a restarted window, with outputs shifted in time, or as a changed `lpc_is_io`, within a few clocks of the stray strobe. The sweep covers every claim slot from 1 to 4, two hold lengths, both cycle types, both enable values, mid-cycle enable toggles and busy-time starts.

// File: rtl/sdc_pkg.sv
// Shared types for the subtractive decode claimer.
package sdc_pkg;

    // Claim sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // waiting for a start strobe
        ST_DIRECT  = 3'd1,  // claiming off: LPC request this cycle
        ST_WAIT    = 3'd2,  // external decode clocks running
        ST_CLAIM   = 3'd3,  // subtractive window: DEVSEL driven
        ST_STOP    = 3'd4,  // DEVSEL and STOP driven
        ST_RELEASE = 3'd5,  // drives released, LPC request
        ST_EXT     = 3'd6,  // external agent owns the cycle
        ST_DONE    = 3'd7   // external cycle finished
    } sdc_state_e;

endpackage

// File: rtl/sdc_slot_timer.sv
// Decode-slot counter. It counts the external decode clocks after a start.
// Assumes: load and advance are never both high; SUB_SLOT >= 2.
module sdc_slot_timer #(
    parameter int SUB_SLOT = 4,
    localparam int CNT_W = (SUB_SLOT > 2) ? $clog2(SUB_SLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output logic [CNT_W-1:0] slot,
    output logic             last_slot
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SUB_SLOT - 1);

    logic [CNT_W-1:0] slot_q;

    // Slot index: set to 1 at the start, then stepped once per unclaimed decode clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (load) begin
            slot_q <= CNT_W'(1);
        end else if (advance) begin
            slot_q <= slot_q + CNT_W'(1);
        end
    end

    assign slot      = slot_q;
    assign last_slot = (slot_q == LAST_IDX);

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (slot_q < LAST_IDX));

endmodule

// File: rtl/sdc_claim_fsm.sv
// Claim sequencer. It decides between the direct LPC route, waiting for an
// external claim, claiming in the subtractive window, and tracking an
// external cycle to its end.
// Assumes: ext_devsel_n is already synchronous to clk.
module sdc_claim_fsm
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_is_io,
    input  logic       sub_en,
    input  logic       ext_devsel_n,
    input  logic       last_slot,
    output logic       timer_load,
    output logic       timer_advance,
    output sdc_state_e state,
    output logic       type_io
);
    sdc_state_e state_q, state_d;
    logic       io_q;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && cyc_start;

    // Next-state selection for one tracked cycle.
    always_comb begin
        state_d       = state_q;
        timer_advance = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (cyc_start) state_d = sub_en ? ST_WAIT : ST_DIRECT;
            ST_DIRECT:  state_d = ST_IDLE;
            ST_WAIT: begin
                if (!ext_devsel_n) begin
                    state_d = ST_EXT;
                end else if (last_slot) begin
                    state_d = ST_CLAIM;
                end else begin
                    timer_advance = 1'b1;
                end
            end
            ST_CLAIM:   state_d = ST_STOP;
            ST_STOP:    state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            ST_EXT:     if (ext_devsel_n) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign timer_load = accept && sub_en;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Cycle type capture, only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      io_q <= 1'b0;
        else if (accept) io_q <= cyc_is_io;
    end

    assign state   = state_q;
    assign type_io = io_q;

    // R8
    type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(io_q));

    // R6
    ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !ext_devsel_n) |=> (state_q == ST_EXT));

    // R3
    late_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLAIM) |-> ($past(state_q) == ST_WAIT && $past(ext_devsel_n)));

    // R4
    stop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> (state_q == ST_RELEASE));

    // R2
    direct_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIRECT) |-> ($past(state_q) == ST_IDLE && !$past(sub_en)));

endmodule

// File: rtl/sdc_pin_drive.sv
// Output decode. It turns the sequencer state into bus drives and pulses.
// Assumes: the state changes only on clk edges, so outputs are stable within a cycle.
module sdc_pin_drive
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sdc_state_e state,
    input  logic       type_io,
    output logic       devsel_n_o,
    output logic       stop_n_o,
    output logic       lpc_route,
    output logic       lpc_is_io,
    output logic       pci_done
);
    // Drive decode from the current state.
    always_comb begin
        devsel_n_o = !(state == ST_CLAIM || state == ST_STOP);
        stop_n_o   = !(state == ST_STOP);
        lpc_route  = (state == ST_DIRECT) || (state == ST_RELEASE);
        pci_done   = (state == ST_DONE);
        lpc_is_io  = type_io;
    end

    // R4
    stop_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n_o |-> !devsel_n_o);

    // R5
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lpc_route && pci_done));

    // R5
    release_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_n_o) |-> (lpc_route && devsel_n_o));

    // R2
    route_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpc_route |=> !lpc_route);

endmodule

// File: rtl/subtractive_claimer.sv
// Subtractive decode claimer, top level. It gives external PCI agents
// SUB_SLOT-1 decode clocks, then claims in the next one, drives STOP and
// requests an LPC reissue. With claiming off, it routes to LPC at once.
// Assumes: one host cycle at a time; inputs synchronous to clk.
module subtractive_claimer #(
    parameter int SUB_SLOT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_is_io,
    input  logic sub_en,
    input  logic ext_devsel_n,
    output logic devsel_n_o,
    output logic stop_n_o,
    output logic lpc_route,
    output logic lpc_is_io,
    output logic pci_done
);
    import sdc_pkg::*;

    localparam int CNT_W = (SUB_SLOT > 2) ? $clog2(SUB_SLOT) : 1;

    logic             timer_load;
    logic             timer_advance;
    logic             last_slot;
    logic [CNT_W-1:0] slot;
    sdc_state_e       state;
    logic             type_io;

    sdc_slot_timer #(.SUB_SLOT(SUB_SLOT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (timer_load),
        .advance   (timer_advance),
        .slot      (slot),
        .last_slot (last_slot)
    );

    sdc_claim_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start     (cyc_start),
        .cyc_is_io     (cyc_is_io),
        .sub_en        (sub_en),
        .ext_devsel_n  (ext_devsel_n),
        .last_slot     (last_slot),
        .timer_load    (timer_load),
        .timer_advance (timer_advance),
        .state         (state),
        .type_io       (type_io)
    );

    sdc_pin_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .type_io    (type_io),
        .devsel_n_o (devsel_n_o),
        .stop_n_o   (stop_n_o),
        .lpc_route  (lpc_route),
        .lpc_is_io  (lpc_is_io),
        .pci_done   (pci_done)
    );

    // R3
    window_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (slot != '0));

endmodule

// File: tb/subtractive_claimer_tb.sv
module subtractive_claimer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic cyc_is_io = 1'b0;
    logic sub_en = 1'b0;
    logic ext_devsel_n = 1'b1;
    logic devsel_n_o, stop_n_o, lpc_route, lpc_is_io, pci_done;

    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    subtractive_claimer #(.SUB_SLOT(4)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .cyc_is_io    (cyc_is_io),
        .sub_en       (sub_en),
        .ext_devsel_n (ext_devsel_n),
        .devsel_n_o   (devsel_n_o),
        .stop_n_o     (stop_n_o),
        .lpc_route    (lpc_route),
        .lpc_is_io    (lpc_is_io),
        .pci_done     (pci_done)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One tracked cycle. slot 0 = no external claim, 1..4 = first cycle with
    // ext_devsel_n low, held for hold cycles.
    task automatic trial(input logic en, input logic io, input int slot, input int hold,
                         input logic extra, input logic tog);
        int    m;
        string tag;
        @(negedge clk);
        cyc_start = 1'b1; cyc_is_io = io; sub_en = en; ext_devsel_n = 1'b1;
        m = slot + hold - 1;
        for (int c = 1; c <= 10; c++) begin
            logic e_dev, e_stop, e_route, e_done;
            @(negedge clk);
            e_dev = 1'b1; e_stop = 1'b1; e_route = 1'b0; e_done = 1'b0;
            if (!en) begin
                tag = "R2";
                e_route = (c == 1);
            end else if (slot >= 1 && slot <= 3) begin
                tag = "R6";
                e_done = (c == m + 2);
            end else begin
                tag = "R3";
                e_dev   = !(c == 4 || c == 5);
                e_stop  = !(c == 5);
                e_route = (c == 6);
            end
            if (extra) tag = {tag, "/R8"};
            if (tog)   tag = {tag, "/R9"};
            chk(tag, "devsel_n_o", devsel_n_o, e_dev);
            chk({tag, "/R4"}, "stop_n_o", stop_n_o, e_stop);
            chk({tag, "/R5"}, "lpc_route", lpc_route, e_route);
            chk({tag, "/R7"}, "pci_done", pci_done, e_done);
            if (e_route) chk({tag, "/R10"}, "lpc_is_io", lpc_is_io, io);
            // drive this cycle's inputs
            cyc_start    = extra && (c == 3);
            cyc_is_io    = ~io;
            sub_en       = tog ? ~en : en;
            ext_devsel_n = !(slot != 0 && c >= slot && c <= m);
        end
        cyc_start = 1'b0; ext_devsel_n = 1'b1; sub_en = en;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held in reset
        chk("R1", "devsel_n_o", devsel_n_o, 1'b1);
        chk("R1", "stop_n_o", stop_n_o, 1'b1);
        chk("R1", "lpc_route", lpc_route, 1'b0);
        chk("R1", "pci_done", pci_done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "devsel_n_o", devsel_n_o, 1'b1);
        chk("R1", "stop_n_o", stop_n_o, 1'b1);
        chk("R1", "lpc_route", lpc_route, 1'b0);
        chk("R1", "pci_done", pci_done, 1'b0);

        for (int e = 0; e < 2; e++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s <= 4; s++)
                    for (int h = 1; h <= 2; h++)
                        for (int x = 0; x < 2; x++)
                            for (int g = 0; g < 2; g++)
                                if (!(e == 0 && x == 1))
                                    trial(e[0], t[0], s, h, x[0], g[0]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule